// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block is the digital control core of an eight-pair differential clock fanout. A divided clock phase is derived from the block clock, either at half the block clock rate or at a quarter of it. Each output pair is put into one of three states: running (true line follows the divided phase and the complement line is its inverse), held (true line high, complement line low, both driven) or off (both lines low with the drive enable removed).

The state of each pair is computed from four sources. The first is the per-pair enable pins. The second is an active-low stop input. The third is an active-low power-down input. A single polarity pin can invert all three of these pin groups. The last source is a small register image written through a simple write port by the serial engine that sits outside this block. State changes are applied only at the instant the divided phase goes from low to high. The divider keeps running while an output is held, so an output that comes back stays in phase with the others.

Top module: `diffclk_gate`

## Requirements
- R1: During reset every pair is off (`out_oe` all 0). After reset the register image holds control 0x03, enable mask 0xFF and free-run mask 0x00. With all pins inactive-default (enables high, stop and power-down high, polarity 0) every pair then runs, which is state code 2'b00 on `out_state`, and `pll_mode`=1 and `pll_bw_low`=0.
- R2: A pair is enabled only when its effective enable pin is 1 and its bit in the enable mask (register address 1, bit i for pair i) is 1. A disabled pair is off: state code 2'b10, `out_oe`=0, `out_p`=0 and `out_n`=0.
- R3: With `pol_inv`=1 the enable pins, `stop_pin_n` and `pwrdn_pin_n` are all inverted before use. With `pol_inv`=0 they are used as given.
- R4: While the effective stop input is low, an enabled pair that is not free-running stops. Control bit 3 (address 0) selects how: 0 gives held, which is state 2'b01 with `out_p`=1 and `out_n`=0; 1 gives off.
- R5: While the effective power-down input is low, every pair stops whatever its enable and free-run bits say. Control bit 4 selects how: 0 gives held, 1 gives off.
- R6: The divided clock is half the block clock rate, so the true line toggles every cycle, unless `div_pin_n` is 0 or control bit 0 is 0. In either of those cases the rate is halved again and the true line toggles every second cycle.
- R7: A pair whose bit is set in the free-run mask (address 2) keeps toggling while stop is asserted. Power-down still stops it.
- R8: A pair changes state only at the edge where the divided phase rises. A pair that turns on therefore starts with its true line high for a full half period.
- R9: Register writes arriving while the effective power-down input is low are discarded.
- R10: Control bit 1 appears on `pll_mode` (1 = PLL, 0 = fanout). Control bit 2 appears on `pll_bw_low` (1 = low bandwidth).
- R11: A pair that resumes after a stop runs in phase with a pair that was free-running through the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin | input | 8 | Per-pair enable pins, active high before polarity |
| pol_inv | input | 1 | Inverts enable, stop and power-down pins when 1 |
| stop_pin_n | input | 1 | Clock stop, active low before polarity |
| pwrdn_pin_n | input | 1 | Power-down, active low before polarity |
| div_pin_n | input | 1 | 0 selects the extra divide by 2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 enable mask, 2 free-run mask |
| reg_wdata | input | 8 | Register write data |
| out_p | output | 8 | True line level per pair |
| out_n | output | 8 | Complement line level per pair |
| out_oe | output | 8 | Drive enable per pair |
| out_state | output | 16 | Two-bit state per pair (00 run, 01 held, 10 off), pair i at bits 2i+1:2i |
| pll_mode | output | 1 | PLL/fanout select from control bit 1 |
| pll_bw_low | output | 1 | Bandwidth select from control bit 2 |

## Verification
The pair-state logic is tried with each stop source alone: a pin disable, a register disable, stop, and power-down. Each is tried with both settings of its driven-or-off bit, so that held and off outputs can be told apart from one another and from a pair that is merely disabled. The same pin patterns are repeated with the polarity pin set, which tells a correct inversion apart from a partial one. Free-run lanes are checked under stop and under power-down, which separates the two priorities. The divider is tried through the pin and through the register bit separately, and the toggle count tells the two rates apart. Each restart is compared against a free-running neighbour to expose any loss of phase.

// File: rtl/diffclk_pkg.sv
`timescale 1ns/1ps
package diffclk_pkg;
  typedef enum logic [1:0] {
    LANE_RUN  = 2'b00,
    LANE_HOLD = 2'b01,
    LANE_OFF  = 2'b10
  } lane_st_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FREE = 2'd2;

  localparam int unsigned CB_DIV_NORM = 0;
  localparam int unsigned CB_PLL_ON   = 1;
  localparam int unsigned CB_BW_LOW   = 2;
  localparam int unsigned CB_STOP_TRI = 3;
  localparam int unsigned CB_PD_TRI   = 4;

  typedef struct packed {
    logic pd_tri;
    logic stop_tri;
    logic bw_low;
    logic pll_on;
    logic div_norm;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pd_tri: 1'b0, stop_tri: 1'b0, bw_low: 1'b0,
                                   pll_on: 1'b1, div_norm: 1'b1};
endpackage

// File: rtl/diffclk_div.sv
`timescale 1ns/1ps
module diffclk_div (
  input  logic clk,
  input  logic rst,
  input  logic div2_req,
  output logic phase_q,
  output logic phase_nxt,
  output logic rise
);
  logic cnt_q, cnt_nxt, div2_q;

  always_comb begin
    if (div2_q) begin
      cnt_nxt   = ~cnt_q;
      phase_nxt = cnt_q ? ~phase_q : phase_q;
    end else begin
      cnt_nxt   = 1'b0;
      phase_nxt = ~phase_q;
    end
    rise = ~phase_q & phase_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      cnt_q   <= 1'b0;
      div2_q  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_nxt;
      if (rise) div2_q <= div2_req;
    end
  end
endmodule

// File: rtl/diffclk_regs.sv
`timescale 1ns/1ps
module diffclk_regs
  import diffclk_pkg::*;
#(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_allow,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  output ctrl_t              ctrl,
  output logic [NUM_OUT-1:0] en_mask,
  output logic [NUM_OUT-1:0] free_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= CTRL_RESET;
      en_mask   <= '1;
      free_mask <= '0;
    end else if (we && wr_allow) begin
      case (addr)
        ADDR_CTRL: begin
          ctrl.div_norm <= wdata[CB_DIV_NORM];
          ctrl.pll_on   <= wdata[CB_PLL_ON];
          ctrl.bw_low   <= wdata[CB_BW_LOW];
          ctrl.stop_tri <= wdata[CB_STOP_TRI];
          ctrl.pd_tri   <= wdata[CB_PD_TRI];
        end
        ADDR_EN:   en_mask   <= wdata[NUM_OUT-1:0];
        ADDR_FREE: free_mask <= wdata[NUM_OUT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/diffclk_lane.sv
`timescale 1ns/1ps
module diffclk_lane
  import diffclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       phase_nxt,
  input  logic       pd_act,
  input  logic       stop_act,
  input  logic       en,
  input  logic       free,
  input  logic       stop_tri,
  input  logic       pd_tri,
  output logic [1:0] st,
  output logic       p_q,
  output logic       n_q,
  output logic       oe_q
);
  lane_st_e st_q, st_nxt, tgt;

  always_comb begin
    if (pd_act)                tgt = pd_tri ? LANE_OFF : LANE_HOLD;
    else if (!en)              tgt = LANE_OFF;
    else if (stop_act && !free) tgt = stop_tri ? LANE_OFF : LANE_HOLD;
    else                       tgt = LANE_RUN;
    st_nxt = rise ? tgt : st_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LANE_OFF;
      p_q  <= 1'b0;
      n_q  <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      case (st_nxt)
        LANE_RUN: begin
          p_q  <= phase_nxt;
          n_q  <= ~phase_nxt;
          oe_q <= 1'b1;
        end
        LANE_HOLD: begin
          p_q  <= 1'b1;
          n_q  <= 1'b0;
          oe_q <= 1'b1;
        end
        default: begin
          p_q  <= 1'b0;
          n_q  <= 1'b0;
          oe_q <= 1'b0;
        end
      endcase
    end
  end

  assign st = st_q;
endmodule

// File: rtl/diffclk_gate.sv
`timescale 1ns/1ps
module diffclk_gate
  import diffclk_pkg::*;
#(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned DW      = 8,
  localparam int unsigned SW     = 2 * NUM_OUT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] oe_pin,
  input  logic               pol_inv,
  input  logic               stop_pin_n,
  input  logic               pwrdn_pin_n,
  input  logic               div_pin_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [NUM_OUT-1:0] out_p,
  output logic [NUM_OUT-1:0] out_n,
  output logic [NUM_OUT-1:0] out_oe,
  output logic [SW-1:0]      out_state,
  output logic               pll_mode,
  output logic               pll_bw_low
);
  ctrl_t              ctrl;
  logic [NUM_OUT-1:0] en_mask, free_mask, oe_eff, lane_en;
  logic               stop_act, pd_act, div2_req;
  logic               dphase, dphase_nxt, drise;

  always_comb begin
    oe_eff   = oe_pin ^ {NUM_OUT{pol_inv}};
    stop_act = ~(stop_pin_n ^ pol_inv);
    pd_act   = ~(pwrdn_pin_n ^ pol_inv);
    lane_en  = oe_eff & en_mask;
    div2_req = ~div_pin_n | ~ctrl.div_norm;
  end

  diffclk_regs #(.NUM_OUT(NUM_OUT), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_allow (~pd_act),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ctrl     (ctrl),
    .en_mask  (en_mask),
    .free_mask(free_mask)
  );

  diffclk_div u_div (
    .clk      (clk),
    .rst      (rst),
    .div2_req (div2_req),
    .phase_q  (dphase),
    .phase_nxt(dphase_nxt),
    .rise     (drise)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    diffclk_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .rise     (drise),
      .phase_nxt(dphase_nxt),
      .pd_act   (pd_act),
      .stop_act (stop_act),
      .en       (lane_en[g]),
      .free     (free_mask[g]),
      .stop_tri (ctrl.stop_tri),
      .pd_tri   (ctrl.pd_tri),
      .st       (out_state[2*g +: 2]),
      .p_q      (out_p[g]),
      .n_q      (out_n[g]),
      .oe_q     (out_oe[g])
    );
  end

  assign pll_mode   = ctrl.pll_on;
  assign pll_bw_low = ctrl.bw_low;
endmodule

// File: rtl/diffclk_gate_chk.sv
`timescale 1ns/1ps
module diffclk_gate_chk #(
  parameter int unsigned NUM_OUT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pol_inv,
  input logic               stop_pin_n,
  input logic               pwrdn_pin_n,
  input logic               reg_we,
  input logic [NUM_OUT-1:0] out_p,
  input logic [NUM_OUT-1:0] out_oe,
  input logic [2*NUM_OUT-1:0] out_state,
  input logic               pll_mode,
  input logic               pll_bw_low,
  input logic               phase,
  input logic               rise,
  input logic [NUM_OUT-1:0] lane_en,
  input logic [NUM_OUT-1:0] free_mask
);
  logic pd_on, stop_on;
  assign pd_on   = ~(pwrdn_pin_n ^ pol_inv);
  assign stop_on = ~(stop_pin_n ^ pol_inv);

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (reg_we && pd_on) |=> ($stable(pll_mode) && $stable(pll_bw_low))); // R9

  AST_CHANGE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_state) |-> $rose(phase)); // R8

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    AST_PD_HALTS: assert property (@(posedge clk) disable iff (rst)
      (rise && pd_on) |=> (out_state[2*i +: 2] != 2'b00)); // R5

    AST_FREE_RUNS: assert property (@(posedge clk) disable iff (rst)
      (rise && stop_on && !pd_on && lane_en[i] && free_mask[i])
        |=> (out_state[2*i +: 2] == 2'b00)); // R7

    AST_ON_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
      $rose(out_oe[i]) |-> out_p[i]); // R8
  end
endmodule

bind diffclk_gate diffclk_gate_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pol_inv    (pol_inv),
  .stop_pin_n (stop_pin_n),
  .pwrdn_pin_n(pwrdn_pin_n),
  .reg_we     (reg_we),
  .out_p      (out_p),
  .out_oe     (out_oe),
  .out_state  (out_state),
  .pll_mode   (pll_mode),
  .pll_bw_low (pll_bw_low),
  .phase      (dphase),
  .rise       (drise),
  .lane_en    (lane_en),
  .free_mask  (free_mask)
);

// File: tb/diffclk_gate_test.sv
`timescale 1ns/1ps
module diffclk_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  oe_pin = 8'hFF;
  logic        pol_inv = 1'b0;
  logic        stop_pin_n = 1'b1;
  logic        pwrdn_pin_n = 1'b1;
  logic        div_pin_n = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  out_p, out_n, out_oe;
  logic [15:0] out_state;
  logic        pll_mode, pll_bw_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  diffclk_gate uut (
    .clk(clk), .rst(rst), .oe_pin(oe_pin), .pol_inv(pol_inv),
    .stop_pin_n(stop_pin_n), .pwrdn_pin_n(pwrdn_pin_n), .div_pin_n(div_pin_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .out_p(out_p), .out_n(out_n), .out_oe(out_oe), .out_state(out_state),
    .pll_mode(pll_mode), .pll_bw_low(pll_bw_low)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic watch(input int idx, input int n, output int tg, output int hi);
    logic prev;
    @(negedge clk);
    prev = out_p[idx]; tg = 0; hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (out_p[idx] != prev) tg++;
      if (out_p[idx]) hi++;
      prev = out_p[idx];
    end
  endtask

  task automatic t_reset;
    int tg, hi;
    cyc(3);
    chk(out_oe == 8'h00, "R1", "oe in reset", out_oe, 8'h00);
    rst = 1'b0;
    cyc(4);
    chk(out_oe == 8'hFF, "R1", "oe after reset", out_oe, 8'hFF);
    chk(out_state == 16'h0000, "R1", "state after reset", out_state, 16'h0000);
    chk(pll_mode == 1'b1 && pll_bw_low == 1'b0, "R1", "pll bits",
        {pll_mode, pll_bw_low}, 2'b10);
    watch(3, 8, tg, hi);
    chk(tg == 8, "R1", "lane3 toggles", tg, 8);
  endtask

  task automatic t_enable;
    oe_pin[5] = 1'b0;
    cyc(6);
    chk(out_oe[5] == 1'b0 && out_p[5] == 1'b0 && out_n[5] == 1'b0, "R2",
        "pin disable lines", {out_oe[5], out_p[5], out_n[5]}, 3'b000);
    chk(out_state[11:10] == 2'b10, "R2", "pin disable state", out_state[11:10], 2'b10);
    oe_pin[5] = 1'b1;
    wr(2'd1, 8'hF7);
    cyc(6);
    chk(out_oe == 8'hF7, "R2", "reg disable lane3", out_oe, 8'hF7);
    wr(2'd1, 8'hFF);
    cyc(6);
  endtask

  task automatic t_div;
    int tg, hi;
    div_pin_n = 1'b0;
    cyc(8);
    watch(0, 8, tg, hi);
    chk(tg == 4, "R6", "pin divide toggles", tg, 4);
    div_pin_n = 1'b1;
    wr(2'd0, 8'h02);
    cyc(8);
    watch(0, 8, tg, hi);
    chk(tg == 4, "R6", "reg divide toggles", tg, 4);
    wr(2'd0, 8'h03);
    cyc(8);
    watch(0, 8, tg, hi);
    chk(tg == 8, "R6", "normal toggles", tg, 8);
  endtask

  task automatic t_stop;
    int tg, hi;
    stop_pin_n = 1'b0;
    cyc(6);
    watch(1, 8, tg, hi);
    chk(tg == 0 && hi == 8, "R4", "held true line", hi, 8);
    chk(out_n[1] == 1'b0 && out_state[3:2] == 2'b01, "R4", "held state",
        {out_n[1], out_state[3:2]}, 3'b001);
    wr(2'd0, 8'h0B);
    cyc(6);
    chk(out_oe[1] == 1'b0 && out_state[3:2] == 2'b10, "R4", "stop off",
        {out_oe[1], out_state[3:2]}, 3'b010);
    wr(2'd0, 8'h03);
    stop_pin_n = 1'b1;
    cyc(6);
    watch(1, 8, tg, hi);
    chk(tg == 8, "R4", "resume toggles", tg, 8);
  endtask

  task automatic t_free;
    int tg, hi;
    int mism;
    wr(2'd2, 8'h01);
    div_pin_n = 1'b0;
    cyc(8);
    stop_pin_n = 1'b0;
    cyc(8);
    watch(0, 8, tg, hi);
    chk(tg == 4, "R7", "free lane under stop", tg, 4);
    chk(out_state[3:2] == 2'b01, "R7", "other lane held", out_state[3:2], 2'b01);
    stop_pin_n = 1'b1;
    cyc(8);
    mism = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (out_p[0] != out_p[1]) mism++;
    end
    chk(mism == 0, "R11", "phase after resume", mism, 0);
    pwrdn_pin_n = 1'b0;
    cyc(8);
    chk(out_state[1:0] == 2'b01, "R7", "free lane under power-down", out_state[1:0], 2'b01);
    pwrdn_pin_n = 1'b1;
    cyc(4);
    wr(2'd2, 8'h00);
    div_pin_n = 1'b1;
    cyc(8);
  endtask

  task automatic t_pd;
    pwrdn_pin_n = 1'b0;
    cyc(6);
    chk(out_state == 16'h5555 && out_p == 8'hFF, "R5", "pd held", out_state, 16'h5555);
    pwrdn_pin_n = 1'b1;
    cyc(4);
    wr(2'd0, 8'h13);
    pwrdn_pin_n = 1'b0;
    cyc(6);
    chk(out_oe == 8'h00 && out_state == 16'hAAAA, "R5", "pd off", out_state, 16'hAAAA);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h07);
    pwrdn_pin_n = 1'b1;
    cyc(6);
    chk(out_oe == 8'hFF, "R9", "enable write dropped", out_oe, 8'hFF);
    chk(pll_bw_low == 1'b0 && pll_mode == 1'b1, "R9", "ctrl write dropped",
        {pll_mode, pll_bw_low}, 2'b10);
    wr(2'd0, 8'h03);
    cyc(4);
  endtask

  task automatic t_pol;
    int tg, hi;
    pol_inv = 1'b1; stop_pin_n = 1'b0; pwrdn_pin_n = 1'b0; oe_pin = 8'h0F;
    cyc(6);
    chk(out_oe == 8'hF0 && out_state[15:8] == 8'h00, "R3", "inverted enables",
        out_oe, 8'hF0);
    stop_pin_n = 1'b1;
    cyc(6);
    watch(6, 6, tg, hi);
    chk(out_state[15:8] == 8'h55 && tg == 0, "R3", "inverted stop", out_state[15:8], 8'h55);
    pwrdn_pin_n = 1'b1;
    cyc(6);
    chk(out_state == 16'h5555, "R3", "inverted power-down", out_state, 16'h5555);
    pol_inv = 1'b0; stop_pin_n = 1'b1; pwrdn_pin_n = 1'b1; oe_pin = 8'hFF;
    cyc(6);
    chk(out_state == 16'h0000, "R3", "polarity restored", out_state, 16'h0000);
  endtask

  task automatic t_pll;
    wr(2'd0, 8'h05);
    chk(pll_mode == 1'b0 && pll_bw_low == 1'b1, "R10", "pll bits",
        {pll_mode, pll_bw_low}, 2'b01);
    wr(2'd0, 8'h03);
    chk(pll_mode == 1'b1 && pll_bw_low == 1'b0, "R10", "pll bits back",
        {pll_mode, pll_bw_low}, 2'b10);
  endtask

  task automatic t_edge;
    int wait_n;
    div_pin_n = 1'b0;
    oe_pin[2] = 1'b0;
    cyc(8);
    oe_pin[2] = 1'b1;
    wait_n = 0;
    @(negedge clk);
    while (!out_oe[2] && wait_n < 8) begin
      @(negedge clk);
      wait_n++;
    end
    chk(out_oe[2] == 1'b1, "R8", "lane turned on", out_oe[2], 1);
    chk(out_p[2] == 1'b1, "R8", "first level high", out_p[2], 1);
    @(negedge clk);
    chk(out_p[2] == 1'b1, "R8", "full high phase", out_p[2], 1);
    @(negedge clk);
    chk(out_p[2] == 1'b0, "R8", "then low", out_p[2], 0);
    div_pin_n = 1'b1;
    cyc(6);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enable();
    t_div();
    t_stop();
    t_free();
    t_pd();
    t_pol();
    t_pll();
    t_edge();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule